// File: doc/BRIEF.md
# AHB Single-Transfer Bus Master

This engine turns one command from a local requester into exactly one AHB transfer of burst type SINGLE. A command carries an address, a direction, a transfer size, a protection code, a burst code, a "no transfer" flag and write data. It is accepted through a valid/ready handshake. For a legal command the engine raises its bus request and waits for the arbiter grant. It then issues a NONSEQ address phase followed by a data phase, and holds its bus values for as long as the slave stalls.

When the data phase ends, the engine reports back with a one-cycle done pulse. The pulse carries the read data and the slave's two-bit response. The engine then returns the address and control lines to zero with HTRANS at IDLE. A command that asks for any burst other than SINGLE, or that asks for no transfer at all, never reaches the bus. It is answered with a done pulse that has the error flag set.

Only one command is in flight at a time. The requester may present the next command as soon as `cmd_ready` is high again.

Top module: `ahbsm_master`

## Requirements
- R1: A synchronous active-high reset, applied at any time including in the middle of a transfer, leaves the engine with these values after one clock edge: HTRANS=2'b00 (IDLE), HADDR, HWRITE, HSIZE, HBURST and HPROT all zero, HBUSREQ=0, done=0 and cmd_ready=1.
- R2: `cmd_ready` is high exactly when no command is outstanding. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low in the cycle after a legal command is taken.
- R3: HBUSREQ is high from the cycle after a legal command is accepted until the address phase is issued, and it is low in the address phase. HTRANS never leaves IDLE unless HGRANT was sampled high on the previous edge while the engine was requesting. A grant seen while idle has no effect.
- R4: In the cycle after the edge at which HGRANT is sampled high, the engine drives HTRANS=2'b10 (NONSEQ), HADDR from the command, HBURST=3'b000 (SINGLE), HSIZE, HPROT, and HWRITE (0 for a read, 1 for a write).
- R5: While HREADY is sampled low during the address phase, HTRANS stays NONSEQ and HADDR and the control lines stay unchanged.
- R6: In the data phase (the cycle after the address phase completes with HREADY high), HTRANS is IDLE, HADDR is still held, and for a write HWDATA carries the command's write data. These values are held while HREADY is low.
- R7: Each transfer produces a done pulse exactly one cycle long, in the cycle after the edge at which HREADY is sampled high in the data phase. The pulse carries done_resp equal to the sampled HRESP and done_err=0. done_rdata is the sampled HRDATA for a read and zero for a write.
- R8: In the cycle after a transfer completes, HTRANS is IDLE and HADDR, HWRITE, HSIZE, HBURST and HPROT are all zero.
- R9: A command with a burst code other than 3'b000, or with `cmd_noxfer` set, causes no bus activity (HBUSREQ and HTRANS stay zero). It yields a done pulse in the cycle after acceptance with done_err=1, done_resp=0 and done_rdata=0.
- R10: HLOCK is always 0, and HTRANS only ever takes the values 2'b00 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (AHB HCLK) |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_addr | input | AW | Transfer address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_size | input | 3 | Transfer size code for HSIZE |
| cmd_burst | input | 3 | Burst code; only 3'b000 is carried out |
| cmd_prot | input | 4 | Protection code for HPROT |
| cmd_noxfer | input | 1 | Request with no bus transfer (answered with an error) |
| cmd_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW | Read data of the completed transfer |
| done_resp | output | 2 | Slave response of the completed transfer |
| done_err | output | 1 | Command was rejected as unsupported |
| hbusreq | output | 1 | Bus request to the arbiter |
| hlock | output | 1 | Locked transfer request, tied low |
| hgrant | input | 1 | Bus grant from the arbiter |
| htrans | output | 2 | Transfer type |
| haddr | output | AW | Address |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hprot | output | 4 | Protection control |
| hwdata | output | DW | Write data |
| hready | input | 1 | Slave ready |
| hrdata | input | DW | Read data |
| hresp | input | 2 | Slave response |

## Verification
All outputs are registered, so every result appears in the cycle after the edge that causes it. HBUSREQ rises one cycle after acceptance, and the NONSEQ address phase appears one cycle after the grant edge. The data phase follows one cycle after an address-phase edge with HREADY high, and both the done pulse and the cleared bus follow one cycle after a data-phase edge with HREADY high. A rejected command's done pulse is due one cycle after acceptance.

The bench drives its inputs on falling edges and checks the bus on the falling edge that follows each of these causing edges, walking stall and grant delays one cycle at a time. A monitor pops the expected completion from a queue on every falling edge where done is high. A pulse that comes late, comes twice or never comes therefore shows up as a mismatch, an unexpected pop or a non-empty queue.

// File: rtl/ahbsm_pkg.sv
package ahbsm_pkg;
  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [2:0] HB_SINGLE = 3'b000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA
  } mst_state_e;
endpackage

// File: rtl/ahbsm_burst_filter.sv
module ahbsm_burst_filter #(
  parameter int BW = 3
) (
  input  logic [BW-1:0] burst,
  input  logic          noxfer,
  output logic          legal
);
  localparam logic [BW-1:0] SINGLE_CODE = '0;

  assign legal = (burst == SINGLE_CODE) && !noxfer;
endmodule

// File: rtl/ahbsm_cmd_hold.sv
module ahbsm_cmd_hold #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic          in_write,
  input  logic [2:0]    in_size,
  input  logic [2:0]    in_burst,
  input  logic [3:0]    in_prot,
  input  logic [DW-1:0] in_wdata,
  output logic [AW-1:0] q_addr,
  output logic          q_write,
  output logic [2:0]    q_size,
  output logic [2:0]    q_burst,
  output logic [3:0]    q_prot,
  output logic [DW-1:0] q_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr  <= '0;
      q_write <= 1'b0;
      q_size  <= '0;
      q_burst <= '0;
      q_prot  <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_addr  <= in_addr;
      q_write <= in_write;
      q_size  <= in_size;
      q_burst <= in_burst;
      q_prot  <= in_prot;
      q_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/ahbsm_completion.sv
module ahbsm_completion #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_ok,
  input  logic          fire_err,
  input  logic          is_read,
  input  logic [DW-1:0] bus_rdata,
  input  logic [1:0]    bus_resp,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [1:0]    resp,
  output logic          err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
      resp  <= '0;
      err   <= 1'b0;
    end else begin
      done <= fire_ok || fire_err;
      if (fire_ok) begin
        rdata <= is_read ? bus_rdata : '0;
        resp  <= bus_resp;
        err   <= 1'b0;
      end else if (fire_err) begin
        rdata <= '0;
        resp  <= '0;
        err   <= 1'b1;
      end
    end
  end

  // R9
  reject_reported_chk: assert property (@(posedge clk) disable iff (rst)
    fire_err |=> (done && err && resp == 2'b00));

  // R7
  good_done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    fire_ok |=> (done && !err));
endmodule

// File: rtl/ahbsm_master.sv
module ahbsm_master
  import ahbsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_write,
  input  logic [2:0]    cmd_size,
  input  logic [2:0]    cmd_burst,
  input  logic [3:0]    cmd_prot,
  input  logic          cmd_noxfer,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic [1:0]    done_resp,
  output logic          done_err,
  output logic          hbusreq,
  output logic          hlock,
  input  logic          hgrant,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [3:0]    hprot,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic [DW-1:0] hrdata,
  input  logic [1:0]    hresp
);
  mst_state_e st;
  logic          legal, accept, take_ok, take_bad;
  logic          addr_done, data_done;
  logic [AW-1:0] q_addr;
  logic          q_write;
  logic [2:0]    q_size, q_burst;
  logic [3:0]    q_prot;
  logic [DW-1:0] q_wdata;

  assign cmd_ready = (st == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign take_ok   = accept && legal;
  assign take_bad  = accept && !legal;
  assign addr_done = (st == ST_ADDR) && hready;
  assign data_done = (st == ST_DATA) && hready;
  assign hlock     = 1'b0;

  ahbsm_burst_filter #(.BW(3)) u_filter (
    .burst  (cmd_burst),
    .noxfer (cmd_noxfer),
    .legal  (legal)
  );

  ahbsm_cmd_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (take_ok),
    .in_addr  (cmd_addr),
    .in_write (cmd_write),
    .in_size  (cmd_size),
    .in_burst (cmd_burst),
    .in_prot  (cmd_prot),
    .in_wdata (cmd_wdata),
    .q_addr   (q_addr),
    .q_write  (q_write),
    .q_size   (q_size),
    .q_burst  (q_burst),
    .q_prot   (q_prot),
    .q_wdata  (q_wdata)
  );

  ahbsm_completion #(.DW(DW)) u_cpl (
    .clk       (clk),
    .rst       (rst),
    .fire_ok   (data_done),
    .fire_err  (take_bad),
    .is_read   (!q_write),
    .bus_rdata (hrdata),
    .bus_resp  (hresp),
    .done      (done),
    .rdata     (done_rdata),
    .resp      (done_resp),
    .err       (done_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      hbusreq <= 1'b0;
      htrans  <= HT_IDLE;
      haddr   <= '0;
      hwrite  <= 1'b0;
      hsize   <= '0;
      hburst  <= '0;
      hprot   <= '0;
      hwdata  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (take_ok) begin
            st      <= ST_REQ;
            hbusreq <= 1'b1;
          end
        end
        ST_REQ: begin
          if (hgrant) begin
            st      <= ST_ADDR;
            hbusreq <= 1'b0;
            htrans  <= HT_NONSEQ;
            haddr   <= q_addr;
            hwrite  <= q_write;
            hsize   <= q_size;
            hburst  <= q_burst;
            hprot   <= q_prot;
          end
        end
        ST_ADDR: begin
          if (addr_done) begin
            st     <= ST_DATA;
            htrans <= HT_IDLE;
            if (q_write) hwdata <= q_wdata;
          end
        end
        ST_DATA: begin
          if (data_done) begin
            st     <= ST_IDLE;
            haddr  <= '0;
            hwrite <= 1'b0;
            hsize  <= '0;
            hburst <= '0;
            hprot  <= '0;
            hwdata <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  legal_trans_chk: assert property (@(posedge clk) disable iff (rst)
    ((htrans == HT_IDLE || htrans == HT_NONSEQ) && !hlock));

  // R3
  grant_before_nonseq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(htrans == HT_NONSEQ) |-> ($past(hgrant) && $past(hbusreq)));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == HT_NONSEQ && !hready) |=>
      (htrans == HT_NONSEQ && $stable(haddr) && $stable(hwrite) && $stable(hsize)));

  // R8
  bus_parked_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (htrans == HT_IDLE && haddr == '0 && !hwrite && hprot == 4'd0));
endmodule

// File: tb/tb_ahbsm_master.sv
`timescale 1ns/1ps
module tb_ahbsm_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic        cmd_write = 1'b0;
  logic [2:0]  cmd_size = '0;
  logic [2:0]  cmd_burst = '0;
  logic [3:0]  cmd_prot = '0;
  logic        cmd_noxfer = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        done;
  logic [31:0] done_rdata;
  logic [1:0]  done_resp;
  logic        done_err;
  logic        hbusreq, hlock;
  logic        hgrant = 1'b0;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic [3:0]  hprot;
  logic [31:0] hwdata;
  logic        hready = 1'b1;
  logic [31:0] hrdata = 32'hDEAD_BEEF;
  logic [1:0]  hresp = 2'b00;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [31:0] rd;
    logic [1:0]  resp;
    logic        err;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  ahbsm_master dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
    .cmd_prot(cmd_prot), .cmd_noxfer(cmd_noxfer), .cmd_wdata(cmd_wdata),
    .done(done), .done_rdata(done_rdata), .done_resp(done_resp), .done_err(done_err),
    .hbusreq(hbusreq), .hlock(hlock), .hgrant(hgrant), .htrans(htrans),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hprot(hprot), .hwdata(hwdata), .hready(hready), .hrdata(hrdata), .hresp(hresp)
  );

  task automatic chk(input bit c, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: completions against the scoreboard (R7, R9)
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7 unexpected done pulse", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(done_err == e.err, e.err ? "R9 error flag" : "R7 error flag", done_err, e.err);
        chk(done_resp == e.resp, e.err ? "R9 response" : "R7 response", done_resp, e.resp);
        chk(done_rdata == e.rd, e.err ? "R9 read data" : "R7 read data", done_rdata, e.rd);
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  task automatic xfer(input logic [31:0] a, input logic w, input logic [2:0] sz,
                      input logic [2:0] bu, input logic nx, input logic [3:0] pr,
                      input logic [31:0] wd, input int gdly, input int astall,
                      input int dstall, input logic [31:0] rd, input logic [1:0] rsp);
    exp_t e;
    bit okb;
    okb = (bu == 3'b000) && !nx;
    chk(cmd_ready == 1'b1, "R2 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_addr = a; cmd_write = w; cmd_size = sz;
    cmd_burst = bu; cmd_noxfer = nx; cmd_prot = pr; cmd_wdata = wd;
    e.err  = !okb;
    e.rd   = (okb && !w) ? rd : 32'd0;
    e.resp = okb ? rsp : 2'b00;
    expq.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!okb) begin
      hgrant = 1'b1;
      for (int i = 0; i < 3; i++) begin
        chk(hbusreq == 1'b0 && htrans == 2'b00, "R9 no bus activity", {hbusreq, htrans}, 0);
        @(negedge clk);
      end
      hgrant = 1'b0;
      return;
    end
    chk(hbusreq == 1'b1, "R3 request after accept", hbusreq, 1);
    chk(cmd_ready == 1'b0, "R2 busy while outstanding", cmd_ready, 0);
    for (int i = 0; i < gdly; i++) begin
      hgrant = 1'b0;
      @(negedge clk);
      chk(hbusreq == 1'b1 && htrans == 2'b00, "R3 wait for grant", {hbusreq, htrans}, 64'h4);
    end
    hgrant = 1'b1;
    @(negedge clk);
    hgrant = 1'b0;
    chk(htrans == 2'b10, "R4 NONSEQ", htrans, 2'b10);
    chk(haddr == a, "R4 address", haddr, a);
    chk({hwrite, hsize, hburst, hprot} == {w, sz, 3'b000, pr}, "R4 control",
        {hwrite, hsize, hburst, hprot}, {w, sz, 3'b000, pr});
    chk(hbusreq == 1'b0, "R3 request dropped in address phase", hbusreq, 0);
    for (int i = 0; i < astall; i++) begin
      hready = 1'b0;
      @(negedge clk);
      chk(htrans == 2'b10 && haddr == a && hwrite == w && hsize == sz, "R5 address held",
          haddr, a);
    end
    hready = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b00, "R6 IDLE in data phase", htrans, 0);
    chk(haddr == a, "R6 address kept in data phase", haddr, a);
    if (w) chk(hwdata == wd, "R6 write data", hwdata, wd);
    for (int i = 0; i < dstall; i++) begin
      hready = 1'b0;
      @(negedge clk);
      chk(haddr == a && (!w || hwdata == wd), "R6 data phase held", hwdata, wd);
      chk(done == 1'b0, "R7 no done while stalled", done, 0);
    end
    hready = 1'b1; hrdata = rd; hresp = rsp;
    @(negedge clk);
    hrdata = 32'hDEAD_BEEF; hresp = 2'b00;
    chk(htrans == 2'b00 && haddr == 32'd0 && {hwrite, hsize, hburst, hprot} == 11'd0,
        "R8 bus cleared", {htrans, haddr}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(htrans == 2'b00 && haddr == 32'd0 && hwrite == 1'b0 && hsize == 3'd0 &&
        hburst == 3'd0 && hprot == 4'd0, "R1 bus idle in reset", {htrans, haddr}, 0);
    chk(hbusreq == 1'b0 && done == 1'b0 && cmd_ready == 1'b1, "R1 handshake in reset",
        {hbusreq, done, cmd_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    // R10 hlock low; R3 grant while idle does nothing
    hgrant = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(htrans == 2'b00 && hbusreq == 1'b0 && hlock == 1'b0, "R3 grant ignored when idle",
          {htrans, hbusreq, hlock}, 0);
    end
    hgrant = 1'b0;
    @(negedge clk);
    // R4 R6 R7 write, immediate grant, no stalls
    xfer(32'h0000_1004, 1'b1, 3'd2, 3'b000, 1'b0, 4'h3, 32'hCAFE_0001, 0, 0, 0, 32'h0, 2'b00);
    // R5 R7 read with grant delay and stalls, resp ERROR
    xfer(32'h0000_2008, 1'b0, 3'd2, 3'b000, 1'b0, 4'h1, 32'h0, 2, 1, 2, 32'h1234_5678, 2'b01);
    // write with halfword size and stalls
    xfer(32'h0000_300A, 1'b1, 3'd1, 3'b000, 1'b0, 4'h2, 32'h5A5A_A5A5, 1, 2, 1, 32'h0, 2'b00);
    // R9 unsupported bursts
    xfer(32'h0000_4000, 1'b0, 3'd2, 3'b001, 1'b0, 4'h0, 32'h0, 0, 0, 0, 32'h0, 2'b00);
    xfer(32'h0000_4004, 1'b1, 3'd2, 3'b011, 1'b0, 4'h0, 32'h77, 0, 0, 0, 32'h0, 2'b00);
    xfer(32'h0000_4008, 1'b0, 3'd2, 3'b110, 1'b0, 4'h0, 32'h0, 0, 0, 0, 32'h0, 2'b00);
    // R9 request with no transfer
    xfer(32'h0000_400C, 1'b0, 3'd2, 3'b000, 1'b1, 4'h0, 32'h0, 0, 0, 0, 32'h0, 2'b00);
    // read right after a rejection
    xfer(32'h0000_5000, 1'b0, 3'd0, 3'b000, 1'b0, 4'hF, 32'h0, 0, 0, 0, 32'h0000_00A5, 2'b00);
    @(negedge clk);
    // R1 reset during an address phase
    cmd_valid = 1'b1; cmd_addr = 32'h0000_6000; cmd_write = 1'b1; cmd_size = 3'd2;
    cmd_burst = 3'b000; cmd_noxfer = 1'b0; cmd_prot = 4'h1; cmd_wdata = 32'h1;
    @(negedge clk);
    cmd_valid = 1'b0; hgrant = 1'b1;
    @(negedge clk);
    hgrant = 1'b0;
    chk(htrans == 2'b10, "R4 NONSEQ before reset", htrans, 2'b10);
    rst = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b00 && haddr == 32'd0 && hwrite == 1'b0 && hprot == 4'd0 && hbusreq == 1'b0,
        "R1 reset mid transfer", {htrans, haddr}, 0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 no done after reset", done, 0);
    // recovery read
    xfer(32'h0000_7FFC, 1'b0, 3'd2, 3'b000, 1'b0, 4'h0, 32'h0, 1, 0, 1, 32'h8765_4321, 2'b00);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R7 every completion seen", expq.size(), 0);
    finish_run();
  end
endmodule